// File: doc/BRIEF.md
# Byte-Lane GPIO Register Bank

This block is a memory-mapped general-purpose I/O peripheral with two 32-bit registers behind a simple bus slave port. The first holds the levels driven onto the pins. The second holds one output-disable bit for each pin. Software writes either register one byte lane at a time under byte enables. A lane is written only when three conditions hold together: a write request, a match on that register's address, and that lane's enable bit.

The block decodes two word addresses above a base that is fixed by a parameter when the design is built. At the data address, a write lands in the output latch. A read at that same address returns the current pin levels, taken through a two-flop synchroniser, and not the latch contents. The direction word can be written and read back at the next word address. Every request is acknowledged in the following cycle. A request to an address that does not decode still receives an acknowledge, returns zero and changes nothing.

Top module: `gpio_lane_bank`

## Requirements
- R1: After reset, `pin_out` is all zeros, `pin_oe_n` is all ones (every driver disabled), and `bus_ack` and `bus_rdata` are zero.
- R2: A write to word address `BASE_ADDR` (offset 0) updates the output latch on `pin_out` one byte lane at a time. Enable bit `bus_be[i]` selects bits `8*i+7 : 8*i`. Lanes whose enable bit is clear keep their old value, and a write with no enable bits set changes nothing.
- R3: A write to `BASE_ADDR + 4` updates the output-disable word on `pin_oe_n`, using the same lane rule as R2. A read at `BASE_ADDR + 4` returns that word.
- R4: A read at `BASE_ADDR` returns the levels on `pin_in`, provided `pin_in` has been held steady for at least three clock cycles before the request. It does not return the output latch.
- R5: Each cycle that carries a read or write request is followed by exactly one cycle with `bus_ack` high. `bus_ack` is never high in a cycle that does not follow a request.
- R6: A request whose word address is neither `BASE_ADDR` nor `BASE_ADDR + 4` is acknowledged with `bus_rdata` of zero, and it changes neither `pin_out` nor `pin_oe_n`.
- R7: A 1 in a bit of `pin_oe_n` disables that pin's driver. The value of `pin_out` follows the latch whatever the direction bits hold.
- R8: When read and write requests arrive in the same cycle, the block performs the write and returns `bus_rdata` of zero with the acknowledge.
- R9: Decoding uses only address bits 2 and above. The two low address bits do not affect which register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the request |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte-lane write enables |
| bus_rd_req | input | 1 | Read request, one cycle per access |
| bus_wr_req | input | 1 | Write request, one cycle per access |
| bus_rdata | output | DATA_W | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Acknowledge, one cycle after a request |
| pin_in | input | DATA_W | Asynchronous pin levels |
| pin_out | output | DATA_W | Output latch driven to the pins |
| pin_oe_n | output | DATA_W | Per-pin output disable, 1 = input |

## Verification
The assertions assume that `bus_addr`, `bus_be` and `bus_wdata` hold known values in every cycle that carries a request. They also assume that requests are sampled only at clock edges, with no other relation between them. The stimulus drives every request field at the falling edge and holds it for exactly one cycle. When a read at the data address is compared, `pin_in` has been held constant for several cycles beforehand, so the synchroniser has settled. Some request cycles deliberately assert both read and write, or carry misaligned low address bits, so the priority and decode properties are exercised.

// File: rtl/gpio_lane_pkg.sv
package gpio_lane_pkg;

    // Register targeted by a bus request after word decode.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } gpio_sel_e;

    localparam int LANE_BITS = 8;
    localparam int WORD_LSB  = 2;

endpackage

// File: rtl/gpio_lane_decode.sv
module gpio_lane_decode
    import gpio_lane_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_sel_e         sel
);
    localparam int WORD_W = ADDR_W - WORD_LSB;
    localparam logic [WORD_W-1:0] DATA_WORD = BASE_ADDR[ADDR_W-1:WORD_LSB];
    localparam logic [WORD_W-1:0] DIR_WORD  = DATA_WORD + 1'b1;

    logic [WORD_W-1:0] word;

    always_comb begin
        word = addr[ADDR_W-1:WORD_LSB];
        if (word == DATA_WORD)
            sel = SEL_DATA;
        else if (word == DIR_WORD)
            sel = SEL_DIR;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/gpio_lane_reg.sv
module gpio_lane_reg
    import gpio_lane_pkg::*;
#(
    parameter int                      LANES   = 4,
    parameter logic [LANES*8-1:0]      RST_VAL = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     lane_en,
    input  logic [LANES*8-1:0]   wdata,
    output logic [LANES*8-1:0]   q
);
    localparam int WIDTH = LANES * LANE_BITS;

    logic [WIDTH-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        for (int i = 0; i < LANES; i++) begin
            if (lane_en[i])
                word_d[i*LANE_BITS +: LANE_BITS] = wdata[i*LANE_BITS +: LANE_BITS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= RST_VAL;
        else
            word_q <= word_d;
    end

    assign q = word_q;

    // R2 / R3: a lane without its enable keeps its contents.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_en[g] |=> $stable(word_q[g*LANE_BITS +: LANE_BITS]));
        a_r2_lane_load: assert property (@(posedge clk) disable iff (!rst_n)
            lane_en[g] |=> word_q[g*LANE_BITS +: LANE_BITS] == $past(wdata[g*LANE_BITS +: LANE_BITS]));
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++)
            stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++)
                stage_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++)
                stage_q[s] <= stage_d[s];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_lane_bank.sv
module gpio_lane_bank
    import gpio_lane_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100,
    parameter int                SYNC_STG  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [DATA_W/8-1:0]  bus_be,
    input  logic                 bus_rd_req,
    input  logic                 bus_wr_req,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_ack,
    input  logic [DATA_W-1:0]    pin_in,
    output logic [DATA_W-1:0]    pin_out,
    output logic [DATA_W-1:0]    pin_oe_n
);
    localparam int LANES = DATA_W / LANE_BITS;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    resp_t             resp_d, resp_q;
    gpio_sel_e         sel;
    logic              wr_go, rd_go;
    logic [LANES-1:0]  data_en, dir_en;
    logic [DATA_W-1:0] data_q, dir_q, pins_sync;

    gpio_lane_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Three-term lane enables: strobe AND register select AND byte enable.
    always_comb begin
        wr_go   = bus_wr_req;
        rd_go   = bus_rd_req & ~bus_wr_req;
        data_en = bus_be & {LANES{wr_go && (sel == SEL_DATA)}};
        dir_en  = bus_be & {LANES{wr_go && (sel == SEL_DIR)}};
    end

    gpio_lane_reg #(
        .LANES   (LANES),
        .RST_VAL ('0)
    ) u_data_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_en (data_en),
        .wdata   (bus_wdata),
        .q       (data_q)
    );

    gpio_lane_reg #(
        .LANES   (LANES),
        .RST_VAL ({DATA_W{1'b1}})
    ) u_dir_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_en (dir_en),
        .wdata   (bus_wdata),
        .q       (dir_q)
    );

    gpio_in_sync #(
        .WIDTH  (DATA_W),
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    always_comb begin
        resp_d.ack   = bus_rd_req | bus_wr_req;
        resp_d.rdata = '0;
        if (rd_go) begin
            case (sel)
                SEL_DATA: resp_d.rdata = pins_sync;
                SEL_DIR:  resp_d.rdata = dir_q;
                default:  resp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            resp_q <= '0;
        else
            resp_q <= resp_d;
    end

    assign bus_ack   = resp_q.ack;
    assign bus_rdata = resp_q.rdata;
    assign pin_out   = data_q;
    assign pin_oe_n  = dir_q;

    a_r5_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_req || bus_wr_req) |=> bus_ack);
    a_r5_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_req || bus_wr_req) |=> !bus_ack);
    a_r6_miss_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |=> ($stable(pin_out) && $stable(pin_oe_n)));
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_req && sel == SEL_NONE) |=> bus_rdata == '0);
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_req && bus_wr_req) |=> bus_rdata == '0);
    a_r3_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_req && !bus_wr_req && sel == SEL_DIR) |=> bus_rdata == $past(pin_oe_n));
    a_r2_data_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_req && sel == SEL_DATA) |=> $stable(pin_out));

endmodule

// File: tb/gpio_lane_bank_bench.sv
module gpio_lane_bank_bench;
    localparam int          DW   = 32;
    localparam int          AW   = 12;
    localparam logic [AW-1:0] BASE = 12'h100;
    localparam logic [AW-1:0] DIRA = 12'h104;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [3:0]    bus_be;
    logic          bus_rd_req, bus_wr_req;
    logic [DW-1:0] bus_rdata;
    logic          bus_ack;
    logic [DW-1:0] pin_in, pin_out, pin_oe_n;

    always #2.5 clk = ~clk;

    gpio_lane_bank #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) u_gpio_lane_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_rd_req(bus_rd_req), .bus_wr_req(bus_wr_req),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe_n(pin_oe_n));

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_val_q [$];
    string         exp_tag_q [$];
    logic [DW-1:0] data_m = '0;
    logic [DW-1:0] dir_m  = '1;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] be);
        logic [DW-1:0] r = old;
        for (int i = 0; i < 4; i++)
            if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    // Driver: one request cycle, expected read data pushed to the scoreboard.
    task automatic access(input bit wr, input bit rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input logic [3:0] be,
                          input logic [DW-1:0] expd, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_be = be;
        bus_wr_req = wr; bus_rd_req = rd;
        exp_val_q.push_back(expd);
        exp_tag_q.push_back(tag);
        if (wr && a[AW-1:2] == BASE[AW-1:2]) data_m = lane_merge(data_m, wd, be);
        if (wr && a[AW-1:2] == DIRA[AW-1:2]) dir_m  = lane_merge(dir_m, wd, be);
        @(negedge clk);
        bus_wr_req = 1'b0; bus_rd_req = 1'b0;
        bus_addr = '0; bus_wdata = '0; bus_be = '0;
    endtask

    task automatic check_pins(input string tag);
        check({tag, " pin_out"}, pin_out, data_m);
        check({tag, " pin_oe_n"}, pin_oe_n, dir_m);
    endtask

    // Monitor: every acknowledge pops one expected item.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && bus_ack === 1'b1) begin
            if (exp_val_q.size() == 0)
                check("R5 unexpected ack", 32'd1, 32'd0);
            else
                check(exp_tag_q.pop_front(), bus_rdata, exp_val_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
        bus_rd_req = 1'b0; bus_wr_req = 1'b0; pin_in = 32'hA5A5_0F0F;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe_n", pin_oe_n, '1);
        check("R1 ack", {31'd0, bus_ack}, '0);
        check("R1 rdata", bus_rdata, '0);

        // R2 full-word and per-lane writes
        access(1, 0, BASE, 32'h1122_3344, 4'hF, '0, "R2 write ack");
        check_pins("R2 full");
        for (int l = 0; l < 4; l++) begin
            access(1, 0, BASE, 32'hDEAD_BEEF ^ (32'h1 << (l*8)), 4'b1 << l, '0, "R2 lane ack");
            check_pins("R2 lane");
        end
        access(1, 0, BASE, 32'hFFFF_FFFF, 4'b0000, '0, "R2 no-enable ack");
        check_pins("R2 no-enable");
        access(1, 0, BASE, 32'h0000_CAFE, 4'b0101, '0, "R2 mixed ack");
        check_pins("R2 mixed");

        // R3 / R7 direction word, lanes and readback
        access(1, 0, DIRA, 32'h0000_0000, 4'b0011, '0, "R3 write ack");
        check_pins("R3 low lanes");
        access(0, 1, DIRA, '0, 4'h0, dir_m, "R3 readback");
        access(1, 0, DIRA, 32'h55AA_0000, 4'b1100, '0, "R3 write ack");
        check_pins("R7 latch independent of direction");
        access(0, 1, DIRA, '0, 4'h0, dir_m, "R3 readback 2");

        // R4 read at data address returns pins, not latch
        pin_in = 32'h0BAD_F00D;
        repeat (4) @(negedge clk);
        access(0, 1, BASE, '0, 4'h0, 32'h0BAD_F00D, "R4 pin read");
        pin_in = 32'h7654_3210;
        repeat (4) @(negedge clk);
        access(0, 1, BASE, '0, 4'h0, 32'h7654_3210, "R4 pin read 2");

        // R6 unmapped addresses
        access(1, 0, 12'h108, 32'h1234_5678, 4'hF, '0, "R6 miss write ack");
        check_pins("R6 miss write");
        access(0, 1, 12'h0FC, '0, 4'h0, '0, "R6 miss read");
        access(0, 1, 12'h000, '0, 4'h0, '0, "R6 miss read low");

        // R8 simultaneous read and write
        access(1, 1, BASE, 32'h9999_8888, 4'hF, '0, "R8 both zero data");
        check_pins("R8 write performed");

        // R9 low address bits ignored
        access(1, 0, 12'h103, 32'h4242_4242, 4'b1000, '0, "R9 write ack");
        check_pins("R9 misaligned data write");
        access(0, 1, 12'h106, '0, 4'h0, dir_m, "R9 misaligned dir read");

        // R5 idle cycles bring no ack; all expected acks consumed
        repeat (6) @(negedge clk);
        check("R5 scoreboard drained", exp_val_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule